// File: doc/BRIEF.md
# Banked Memory Map Controller

This block sits between an 8-bit processor with a 16-bit address bus and three memory devices: a 16K monitor ROM, a 32K main RAM and a 32K expansion device. It decodes every memory cycle into at most one chip select, a translated device address and a write enable. It also holds a three-bit memory-mode register that the processor loads with an I/O write to port 0xFF. The select and address outputs are purely combinational from the bus. The mode register changes only on the clock edge of a qualifying I/O write.

The three mode bits shape the decode. The overlay bit (data bit 0) is set at reset, so that reads from the bottom 2K return the first 2K of the monitor ROM and the processor can fetch its start-up code at address zero. Writes to that range always reach RAM. The guard bit (data bit 1) silently discards writes to the user RAM window at 0x4000–0x7FFF; reads of that window are unaffected. The bank bit (data bit 2) picks which 16K half of the expansion device appears at 0x8000–0xBFFF.

The ROM occupies 0xC000–0xFFFF and general RAM 0x0800–0x3FFF. The RAM device address is the CPU address with bit 15 dropped. The block contains no memory arrays.

Top module: `memmap_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, the mode outputs are overlay=1, guard=0, bank=0.
- R2: An I/O write (io_req=1, wr_en=1) whose low address byte is 0xFF loads overlay from data bit 0, guard from bit 1 and bank from bit 2 at that clock edge. Data bits 7..3 are ignored.
- R3: I/O reads, and I/O writes to any port other than 0xFF, leave the mode outputs unchanged.
- R4: A memory read of 0xC000–0xFFFF asserts rom_cs with rom_addr equal to A13..A0. A memory write to that range asserts no chip select.
- R5: With overlay=1, a memory read of 0x0000–0x07FF asserts rom_cs (ram_cs=0) with rom_addr equal to A13..A0, which is ROM offset 0x000–0x7FF.
- R6: A memory write to 0x0000–0x07FF always asserts ram_cs and ram_we, with ram_addr equal to A14..A0. With overlay=0, reads of that range also select RAM.
- R7: Memory reads and writes of 0x0800–0x3FFF assert ram_cs, with ram_addr equal to A14..A0 and ram_we equal to wr_en.
- R8: With guard=1, a memory write to 0x4000–0x7FFF asserts neither ram_cs nor ram_we, while reads there select RAM. With guard=0, writes there select RAM with ram_we=1.
- R9: A memory access to 0x8000–0xBFFF asserts exp_cs with exp_addr = {bank, A13..A0} and exp_we equal to wr_en.
- R10: No chip select is asserted unless mem_req=1, io_req=0 and rd_en or wr_en is 1. At most one of rom_cs, ram_cs and exp_cs is high at any time. When rd_en and wr_en are both high, the cycle is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data bus |
| mem_req | input | 1 | Memory cycle request |
| io_req | input | 1 | I/O cycle request |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rom_cs | output | 1 | Monitor ROM select |
| rom_addr | output | 14 | ROM word address |
| ram_cs | output | 1 | Main RAM select |
| ram_we | output | 1 | Main RAM write enable |
| ram_addr | output | 15 | RAM word address |
| exp_cs | output | 1 | Expansion device select |
| exp_we | output | 1 | Expansion device write enable |
| exp_addr | output | 15 | Expansion device address including bank bit |
| mode_overlay | output | 1 | Overlay bit state |
| mode_guard | output | 1 | Write-guard bit state |
| mode_bank | output | 1 | Expansion bank bit state |

## Verification
The bench probes both edges of the overlay zone, 0x0000 and 0x07FF, then crosses into 0x0800. A decoder with a wrong zone width would send one of those accesses to the wrong device. It writes into the overlay zone while the overlay is on, which catches a design that lets the ROM capture writes. It also writes to 0x5000 and to 0x3FFF with the guard on, which catches a guard window that is too wide or that blocks reads. The bench loads the port with upper data bits set, and writes to a port whose high address byte is nonzero. A design that decodes too many bits, or too few, would then corrupt the mode. Further checks cover the bank bit at both ends of the window and a mid-run reset, which must bring back only the overlay bit.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  // Mode register layout: bit 0 overlay, bit 1 guard, bit 2 bank.
  typedef struct packed {
    logic bank;
    logic guard;
    logic overlay;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam mode_t MODE_RESET = '{bank: 1'b0, guard: 1'b0, overlay: 1'b1};

  typedef enum logic [2:0] {
    ZONE_OVERLAY = 3'd0,
    ZONE_GENRAM  = 3'd1,
    ZONE_USER    = 3'd2,
    ZONE_WINDOW  = 3'd3,
    ZONE_MONITOR = 3'd4
  } zone_e;

endpackage

// File: rtl/memmap_mode_reg.sv
module memmap_mode_reg
  import memmap_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                PORT_W    = 8,
  parameter logic [PORT_W-1:0] CTRL_PORT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] port,
  input  logic [DATA_W-1:0] wdata,
  output mode_t             mode_q
);

  localparam int SPARE_W = DATA_W - MODE_W;

  logic  load_en;
  mode_t mode_d;
  logic [SPARE_W-1:0] unused_wdata_hi;

  assign unused_wdata_hi = wdata[DATA_W-1:MODE_W];

  // Next-state logic
  always_comb begin
    load_en = io_req & wr_en & (port == CTRL_PORT);
    mode_d  = mode_q;
    if (load_en) begin
      mode_d = mode_t'(wdata[MODE_W-1:0]);
    end
  end

  // State register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
    end else if (load_en) begin
      mode_q <= mode_d;
    end
  end

  // R1: the first edge after release still shows the reset value
  assert_reset_value_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mode_q == MODE_RESET));

  // R2: a control-port write is visible one edge later
  assert_port_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && wr_en && port == CTRL_PORT) |=> (mode_q == $past(wdata[MODE_W-1:0])));

  // R3: any other cycle leaves the register alone
  assert_mode_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && wr_en && port == CTRL_PORT) |=> $stable(mode_q));

endmodule

// File: rtl/memmap_zone_dec.sv
module memmap_zone_dec
  import memmap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OVERLAY_AW = 11
) (
  input  logic [ADDR_W-1:OVERLAY_AW] addr_hi,
  output zone_e                      zone
);

  localparam int QTR_LSB = ADDR_W - 2;

  logic [1:0] quarter;
  logic       in_overlay;

  always_comb begin
    quarter    = addr_hi[ADDR_W-1:QTR_LSB];
    in_overlay = (addr_hi[QTR_LSB-1:OVERLAY_AW] == '0);
    unique case (quarter)
      2'b00:   zone = in_overlay ? ZONE_OVERLAY : ZONE_GENRAM;
      2'b01:   zone = ZONE_USER;
      2'b10:   zone = ZONE_WINDOW;
      default: zone = ZONE_MONITOR;
    endcase
  end

endmodule

// File: rtl/memmap_sel_gen.sv
module memmap_sel_gen
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  zone_e             zone,
  input  mode_t             mode,
  input  logic              access,
  input  logic              is_wr,
  input  logic [ADDR_W-2:0] addr_lo,
  output logic              rom_cs,
  output logic [ADDR_W-3:0] rom_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [ADDR_W-2:0] ram_addr,
  output logic              exp_cs,
  output logic              exp_we,
  output logic [ADDR_W-2:0] exp_addr
);

  localparam int WIN_AW = ADDR_W - 2;

  logic rom_hit;
  logic ram_hit;
  logic exp_hit;

  always_comb begin
    rom_hit = 1'b0;
    ram_hit = 1'b0;
    exp_hit = 1'b0;
    unique case (zone)
      ZONE_OVERLAY: begin
        if (mode.overlay && !is_wr) rom_hit = 1'b1;
        else                        ram_hit = 1'b1;
      end
      ZONE_GENRAM:  ram_hit = 1'b1;
      ZONE_USER:    ram_hit = !(is_wr && mode.guard);
      ZONE_WINDOW:  exp_hit = 1'b1;
      ZONE_MONITOR: rom_hit = !is_wr;
      default: ;
    endcase
  end

  // The monitor lives at the top quarter, so the overlay zone's offset
  // from 0x0000 equals its ROM offset: one address path serves both.
  always_comb begin
    rom_cs   = access & rom_hit;
    ram_cs   = access & ram_hit;
    exp_cs   = access & exp_hit;
    ram_we   = ram_cs & is_wr;
    exp_we   = exp_cs & is_wr;
    rom_addr = addr_lo[WIN_AW-1:0];
    ram_addr = addr_lo;
    exp_addr = {mode.bank, addr_lo[WIN_AW-1:0]};
  end

endmodule

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                PORT_W     = 8,
  parameter int                OVERLAY_AW = 11,
  parameter logic [PORT_W-1:0] CTRL_PORT  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              mem_req,
  input  logic              io_req,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic              rom_cs,
  output logic [ADDR_W-3:0] rom_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [ADDR_W-2:0] ram_addr,
  output logic              exp_cs,
  output logic              exp_we,
  output logic [ADDR_W-2:0] exp_addr,
  output logic              mode_overlay,
  output logic              mode_guard,
  output logic              mode_bank
);

  mode_t mode_q;
  zone_e zone;
  logic  access;

  assign access = mem_req & ~io_req & (rd_en | wr_en);

  memmap_mode_reg #(
    .DATA_W(DATA_W), .PORT_W(PORT_W), .CTRL_PORT(CTRL_PORT)
  ) mode_i (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .wr_en(wr_en),
    .port(cpu_addr[PORT_W-1:0]), .wdata(cpu_wdata), .mode_q(mode_q)
  );

  memmap_zone_dec #(
    .ADDR_W(ADDR_W), .OVERLAY_AW(OVERLAY_AW)
  ) zone_i (
    .addr_hi(cpu_addr[ADDR_W-1:OVERLAY_AW]), .zone(zone)
  );

  memmap_sel_gen #(
    .ADDR_W(ADDR_W)
  ) sel_i (
    .zone(zone), .mode(mode_q), .access(access), .is_wr(wr_en),
    .addr_lo(cpu_addr[ADDR_W-2:0]),
    .rom_cs(rom_cs), .rom_addr(rom_addr),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
    .exp_cs(exp_cs), .exp_we(exp_we), .exp_addr(exp_addr)
  );

  assign mode_overlay = mode_q.overlay;
  assign mode_guard   = mode_q.guard;
  assign mode_bank    = mode_q.bank;

  // R4: monitor reads map straight through, writes select nothing
  assert_monitor_read_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !io_req && rd_en && !wr_en && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b11)
    |-> (rom_cs && rom_addr == cpu_addr[ADDR_W-3:0]));
  assert_monitor_nowrite_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b11) |-> !(rom_cs || ram_cs || exp_cs));

  // R5: overlay reads come from ROM
  assert_overlay_read_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_overlay && mem_req && !io_req && rd_en && !wr_en &&
     cpu_addr[ADDR_W-1:OVERLAY_AW] == '0) |-> (rom_cs && !ram_cs));

  // R6: overlay-zone writes always land in RAM
  assert_overlay_write_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !io_req && wr_en && cpu_addr[ADDR_W-1:OVERLAY_AW] == '0)
    |-> (ram_cs && ram_we && !rom_cs));

  // R8: guarded writes never reach RAM
  assert_guard_drop_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_guard && wr_en && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b01) |-> !(ram_cs || ram_we));

  // R9: the bank bit drives the expansion address MSB
  assert_bank_msb_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    exp_cs |-> (exp_addr[ADDR_W-2] == mode_bank));

  // R10: selects are exclusive and need a memory cycle
  assert_one_select_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs, exp_cs}));
  assert_idle_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req || io_req || !(rd_en || wr_en)) |-> !(rom_cs || ram_cs || exp_cs));

endmodule

// File: tb/memmap_ctrl_tb_top.sv
`timescale 1ns/1ps
module memmap_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        mem_req, io_req, rd_en, wr_en;
  logic        rom_cs, ram_cs, ram_we, exp_cs, exp_we;
  logic [13:0] rom_addr;
  logic [14:0] ram_addr, exp_addr;
  logic        mode_overlay, mode_guard, mode_bank;

  int checks;
  int errors;
  bit done;

  memmap_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_req(mem_req), .io_req(io_req), .rd_en(rd_en), .wr_en(wr_en),
    .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_addr(ram_addr), .exp_cs(exp_cs), .exp_we(exp_we), .exp_addr(exp_addr),
    .mode_overlay(mode_overlay), .mode_guard(mode_guard), .mode_bank(mode_bank)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    string       tag;
    logic        rom_cs;
    logic [13:0] rom_addr;
    logic        ram_cs;
    logic        ram_we;
    logic [14:0] ram_addr;
    logic        exp_cs;
    logic        exp_we;
    logic [14:0] exp_addr;
    logic [2:0]  mode;
  } exp_t;

  exp_t sb_q[$];
  logic [2:0] mdl_mode;  // {bank, guard, overlay}

  // Expected outputs from the requirements
  function automatic exp_t predict(string tag, logic [15:0] a, logic [7:0] d,
                                   logic mq, logic iq, logic rd, logic wr,
                                   logic [2:0] m);
    exp_t e;
    e = '{tag: tag, rom_cs: 0, rom_addr: 0, ram_cs: 0, ram_we: 0, ram_addr: 0,
          exp_cs: 0, exp_we: 0, exp_addr: 0, mode: m};
    if (iq && wr && a[7:0] == 8'hFF) e.mode = d[2:0];
    if (mq && !iq && (rd || wr)) begin
      if (a >= 16'hC000) begin
        if (!wr) begin e.rom_cs = 1; e.rom_addr = a[13:0]; end
      end else if (a >= 16'h8000) begin
        e.exp_cs = 1; e.exp_we = wr; e.exp_addr = {m[2], a[13:0]};
      end else if (a >= 16'h4000) begin
        if (!(wr && m[1])) begin e.ram_cs = 1; e.ram_we = wr; e.ram_addr = a[14:0]; end
      end else if (a < 16'h0800 && m[0] && !wr) begin
        e.rom_cs = 1; e.rom_addr = a[13:0];
      end else begin
        e.ram_cs = 1; e.ram_we = wr; e.ram_addr = a[14:0];
      end
    end
    return e;
  endfunction

  // Driver: apply one bus cycle and queue its expectation
  task automatic drive(string tag, logic [15:0] a, logic [7:0] d,
                       logic mq, logic iq, logic rd, logic wr);
    exp_t e;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; mem_req = mq; io_req = iq; rd_en = rd; wr_en = wr;
    e = predict(tag, a, d, mq, iq, rd, wr, mdl_mode);
    sb_q.push_back(e);
    mdl_mode = e.mode;
  endtask

  task automatic idle_bus();
    @(negedge clk);
    cpu_addr = 16'h0000; cpu_wdata = 8'h00;
    mem_req = 0; io_req = 0; rd_en = 0; wr_en = 0;
  endtask

  // Monitor: pop and compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        logic ok;
        e = sb_q.pop_front();
        checks++;
        ok = (rom_cs == e.rom_cs) && (ram_cs == e.ram_cs) && (ram_we == e.ram_we) &&
             (exp_cs == e.exp_cs) && (exp_we == e.exp_we) &&
             ({mode_bank, mode_guard, mode_overlay} == e.mode) &&
             (!e.rom_cs || rom_addr == e.rom_addr) &&
             (!e.ram_cs || ram_addr == e.ram_addr) &&
             (!e.exp_cs || exp_addr == e.exp_addr);
        if (!ok) begin
          errors++;
          $display("FAIL %s act rom=%b/%h ram=%b%b/%h exp=%b%b/%h mode=%b exp rom=%b/%h ram=%b%b/%h exp=%b%b/%h mode=%b",
                   e.tag, rom_cs, rom_addr, ram_cs, ram_we, ram_addr, exp_cs, exp_we, exp_addr,
                   {mode_bank, mode_guard, mode_overlay},
                   e.rom_cs, e.rom_addr, e.ram_cs, e.ram_we, e.ram_addr,
                   e.exp_cs, e.exp_we, e.exp_addr, e.mode);
        end
      end
    end
  end

  task automatic check_reset_state(string tag);
    checks++;
    if ({mode_bank, mode_guard, mode_overlay} != 3'b001 || rom_cs || ram_cs || exp_cs) begin
      errors++;
      $display("FAIL %s act mode=%b cs=%b%b%b exp mode=001 cs=000", tag,
               {mode_bank, mode_guard, mode_overlay}, rom_cs, ram_cs, exp_cs);
    end
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 0;
    cpu_addr = 16'h0000; cpu_wdata = 8'h00;
    mem_req = 0; io_req = 0; rd_en = 0; wr_en = 0;
    mdl_mode = 3'b001;
    repeat (3) @(posedge clk);
    #1 check_reset_state("R1 power-on");
    @(negedge clk) rst_n = 1;
    drive("R1 first cycle after release", 16'h1000, 8'h00, 0, 0, 0, 0);

    // Overlay zone with overlay on
    drive("R5 read 0x0000",       16'h0000, 8'h00, 1, 0, 1, 0);
    drive("R5 read 0x07FF",       16'h07FF, 8'h00, 1, 0, 1, 0);
    drive("R7 read 0x0800",       16'h0800, 8'h00, 1, 0, 1, 0);
    drive("R6 write 0x0005 ov=1", 16'h0005, 8'h5A, 1, 0, 0, 1);
    drive("R10 rd+wr is write",   16'h0006, 8'h00, 1, 0, 1, 1);
    // Monitor ROM
    drive("R4 read 0xC123",       16'hC123, 8'h00, 1, 0, 1, 0);
    drive("R4 read 0xFFFF",       16'hFFFF, 8'h00, 1, 0, 1, 0);
    drive("R4 write 0xE000",      16'hE000, 8'h11, 1, 0, 0, 1);
    // General RAM
    drive("R7 write 0x2000",      16'h2000, 8'h22, 1, 0, 0, 1);
    drive("R7 read 0x3FFF",       16'h3FFF, 8'h00, 1, 0, 1, 0);
    // Mode port decoding
    drive("R3 io write port 0x12", 16'h0012, 8'h07, 0, 1, 0, 1);
    drive("R3 io write port 0xFE", 16'h12FE, 8'h07, 0, 1, 0, 1);
    drive("R3 io read port 0xFF",  16'h00FF, 8'h07, 0, 1, 1, 0);
    drive("R2 load 0xF8 upper ignored", 16'h00FF, 8'hF8, 0, 1, 0, 1);
    drive("R6 read 0x0010 ov=0",   16'h0010, 8'h00, 1, 0, 1, 0);
    drive("R6 read 0x07FF ov=0",   16'h07FF, 8'h00, 1, 0, 1, 0);
    // Guard
    drive("R8 write 0x5000 guard=0", 16'h5000, 8'h33, 1, 0, 0, 1);
    drive("R2 load guard high port", 16'hAAFF, 8'h02, 0, 1, 0, 1);
    drive("R8 write 0x5000 guard=1", 16'h5000, 8'h33, 1, 0, 0, 1);
    drive("R8 write 0x7FFF guard=1", 16'h7FFF, 8'h33, 1, 0, 0, 1);
    drive("R8 read 0x5000 guard=1",  16'h5000, 8'h00, 1, 0, 1, 0);
    drive("R8 write 0x3FFF guard=1", 16'h3FFF, 8'h44, 1, 0, 0, 1);
    // Expansion bank
    drive("R9 read 0x9234 bank=0",  16'h9234, 8'h00, 1, 0, 1, 0);
    drive("R2 load bank+guard",     16'h00FF, 8'h06, 0, 1, 0, 1);
    drive("R9 read 0x8000 bank=1",  16'h8000, 8'h00, 1, 0, 1, 0);
    drive("R9 write 0xBFFF bank=1", 16'hBFFF, 8'h55, 1, 0, 0, 1);
    // Idle and mixed cycles
    drive("R10 no mem_req",         16'hC000, 8'h00, 0, 0, 1, 0);
    drive("R10 no strobe",          16'h2000, 8'h00, 1, 0, 0, 0);
    drive("R10 mem with io_req",    16'h9000, 8'h00, 1, 1, 1, 0);
    idle_bus();
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);

    // Mid-run reset restores only the overlay bit
    @(negedge clk) rst_n = 0;
    #1 check_reset_state("R1 mid-run reset");
    mdl_mode = 3'b001;
    @(negedge clk) rst_n = 1;
    drive("R5 read 0x0100 after reset", 16'h0100, 8'h00, 1, 0, 1, 0);
    drive("R8 write 0x4000 after reset", 16'h4000, 8'h66, 1, 0, 0, 1);
    idle_bus();
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule